// File: doc/BRIEF.md
# Multichannel Bipolar Transmit Pulse Sequencer

This block times the transmit pulses for sixteen channels of an ultrasound transmit beamformer. For each channel, software-side logic writes a firing delay and a pulse width through a small write port (chip select, address, 16-bit data). A common fire strobe starts a firing. Each channel waits its own delay, then drives a positive half-pulse, then a negative half-pulse of the same width, with a dead unit between phases. At all other times the channel's clamp output is active. The outputs are logic level and feed external high-voltage drivers. Four copies of the block cover a 64-element aperture.

The block clock `clk` is the half-period tick formed from the two phases of the 40 MHz transmit clock, so one count is 12.5 ns. An odd delay therefore starts a channel on the second phase, and an even delay starts it on the first. Writes go to shadow registers, and only an accepted fire copies them into the active set. New values can therefore be loaded during a firing without disturbing it. A transmit-voltage select flag, also written through the port, is latched per firing so that low-voltage and high-voltage firings can interleave.

Top module: `tx_pulse_seq`

## Requirements
- R1: After reset, and whenever `busy` is low, every `tx_clamp` bit is 1, every `tx_pos` and `tx_neg` bit is 0, and after reset `busy` and `hv_sel` are 0.
- R2: A write occurs on a clock edge with `cs` high. An address with bit 5 = 0 and bit 4 = 0 loads the delay of channel addr[3:0] from wdata[9:0]. An address with bit 5 = 0 and bit 4 = 1 loads the width of channel addr[3:0] from wdata[7:0]. Any address with bit 5 = 1 loads the voltage select from wdata[0].
- R3: Let t count clock edges after the accepted fire edge, with t = 0 visible just after that edge. For a channel with delay d and width w > 0, the outputs are: clamp for t < d; all low at t = d; pos for d+1 <= t < d+1+w; all low at t = d+1+w; neg for d+w+2 <= t < d+2w+2; all low at t = d+2w+2; clamp afterwards.
- R4: At most one of pos, neg and clamp of a channel is high in any cycle.
- R5: Between any two different active outputs of a channel there is at least one cycle in which none is high.
- R6: A channel whose active width is 0 keeps clamp high and pos and neg low for the whole firing.
- R7: Writes change only the shadow values. The active delay, width and voltage select are replaced only on an accepted fire, so writes made during a firing apply from the next firing onward.
- R8: A fire strobe while `busy` is high is ignored, and the running firing continues on its original schedule.
- R9: `busy` rises on the edge that accepts a fire. It stays high through t = max over channels with w > 0 of (d+2w+2), or through t = 0 only if all widths are 0. It is low in the next cycle.
- R10: `hv_sel` takes the shadow voltage select on an accepted fire and holds it until the next accepted fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-period tick clock (two phases of 40 MHz) |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Write strobe for the configuration port |
| addr | input | 6 | Write address (see R2) |
| wdata | input | 16 | Write data |
| fire | input | 1 | Start a firing when idle |
| busy | output | 1 | Firing in progress |
| hv_sel | output | 1 | Transmit voltage select for the current firing (1 = high supply) |
| tx_pos | output | 16 | Positive-drive pulse per channel |
| tx_neg | output | 16 | Negative-drive pulse per channel |
| tx_clamp | output | 16 | Clamp per channel |

## Verification
The dead-time and stability properties assume that `fire` and `cs` are synchronous to `clk` and change only between edges. They also assume that a write and an accepted fire never occur on the same edge, since that case is not given a defined priority. The bench drives all inputs on the falling edge. It issues its mid-firing writes only once the fire edge has passed, and it places its extra fire strobe well inside a running firing, so each such stimulus stays within these assumptions.

// File: rtl/txp_pkg.sv
`timescale 1ns/1ps
package txp_pkg;
  localparam int DLY_W  = 10;
  localparam int WID_W  = 8;
  localparam int DATA_W = 16;
  localparam int T_W    = ((DLY_W > WID_W + 1) ? DLY_W : WID_W + 1) + 1;

  typedef enum logic [1:0] {PH_CLAMP, PH_DEAD, PH_POS, PH_NEG} phase_e;

  // end of last dead unit of a channel's sequence
  function automatic logic [T_W-1:0] seq_end(input logic [DLY_W-1:0] d,
                                             input logic [WID_W-1:0] w);
    return T_W'(d) + T_W'(w) + T_W'(w) + T_W'(2);
  endfunction

  function automatic phase_e phase_at(input logic [T_W-1:0] t,
                                      input logic [DLY_W-1:0] d,
                                      input logic [WID_W-1:0] w);
    logic [T_W-1:0] s_pos, s_gap, s_neg, s_end;
    s_pos = T_W'(d) + T_W'(1);
    s_gap = s_pos + T_W'(w);
    s_neg = s_gap + T_W'(1);
    s_end = seq_end(d, w);
    if (w == '0)              return PH_CLAMP;
    else if (t < T_W'(d))     return PH_CLAMP;
    else if (t < s_pos)       return PH_DEAD;
    else if (t < s_gap)       return PH_POS;
    else if (t < s_neg)       return PH_DEAD;
    else if (t < s_end)       return PH_NEG;
    else if (t == s_end)      return PH_DEAD;
    else                      return PH_CLAMP;
  endfunction

  function automatic logic seq_done(input logic [T_W-1:0] t,
                                    input logic [DLY_W-1:0] d,
                                    input logic [WID_W-1:0] w);
    return (w == '0) || (t >= seq_end(d, w));
  endfunction
endpackage

// File: rtl/txp_regs.sv
`timescale 1ns/1ps
module txp_regs
  import txp_pkg::*;
#(
  parameter int N_CH   = 16,
  parameter int ADDR_W = $clog2(N_CH) + 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cs,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [DATA_W-1:0]               wdata,
  input  logic                            load,
  output logic [N_CH-1:0][DLY_W-1:0]      act_d,
  output logic [N_CH-1:0][WID_W-1:0]      act_w,
  output logic                            act_hv
);
  localparam int CH_W = $clog2(N_CH);

  logic [N_CH-1:0][DLY_W-1:0] shd_d;
  logic [N_CH-1:0][WID_W-1:0] shd_w;
  logic                       shd_hv;
  logic                       hit_d, hit_w, hit_hv;
  logic [CH_W-1:0]            ch_sel;
  logic                       unused_hi;

  assign hit_hv    = cs &&  addr[ADDR_W-1];
  assign hit_w     = cs && !addr[ADDR_W-1] &&  addr[ADDR_W-2];
  assign hit_d     = cs && !addr[ADDR_W-1] && !addr[ADDR_W-2];
  assign ch_sel    = addr[CH_W-1:0];
  assign unused_hi = ^wdata[DATA_W-1:DLY_W];

  for (genvar i = 0; i < N_CH; i++) begin : g_shadow
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shd_d[i] <= '0;
        shd_w[i] <= '0;
      end else begin
        if (hit_d && ch_sel == CH_W'(i)) shd_d[i] <= wdata[DLY_W-1:0];
        if (hit_w && ch_sel == CH_W'(i)) shd_w[i] <= wdata[WID_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_hv <= 1'b0;
      act_d  <= '0;
      act_w  <= '0;
      act_hv <= 1'b0;
    end else begin
      if (hit_hv) shd_hv <= wdata[0];
      if (load) begin
        act_d  <= shd_d;
        act_w  <= shd_w;
        act_hv <= shd_hv;
      end
    end
  end

  AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(act_d) && $stable(act_w) && $stable(act_hv))); // R7
endmodule

// File: rtl/txp_ctrl.sv
`timescale 1ns/1ps
module txp_ctrl
  import txp_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fire,
  input  logic           all_done,
  output logic           busy,
  output logic           load,
  output logic [T_W-1:0] t
);
  assign load = fire && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      t    <= '0;
    end else if (load) begin
      busy <= 1'b1;
      t    <= '0;
    end else if (busy) begin
      if (all_done) busy <= 1'b0;
      else          t    <= t + T_W'(1);
    end
  end

  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(fire) && t == '0)); // R9
  AST_FIRE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fire && !all_done) |=> (busy && t == $past(t) + T_W'(1))); // R8
  AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && all_done && !fire) |=> !busy); // R9
endmodule

// File: rtl/txp_chan.sv
`timescale 1ns/1ps
module txp_chan
  import txp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic [T_W-1:0]   t,
  input  logic [DLY_W-1:0] d,
  input  logic [WID_W-1:0] w,
  output logic             pos,
  output logic             neg,
  output logic             clamp,
  output logic             done
);
  phase_e ph;

  assign ph    = busy ? phase_at(t, d, w) : PH_CLAMP;
  assign pos   = (ph == PH_POS);
  assign neg   = (ph == PH_NEG);
  assign clamp = (ph == PH_CLAMP);
  assign done  = seq_done(t, d, w);

  AST_DEAD_BEFORE_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    neg |-> (!$past(pos) && !$past(clamp))); // R5
  AST_DEAD_BEFORE_POS: assert property (@(posedge clk) disable iff (!rst_n)
    pos |-> (!$past(neg) && !$past(clamp))); // R5
  AST_DEAD_BEFORE_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    clamp |-> (!$past(pos) && !$past(neg))); // R5
  AST_ZERO_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (w == '0) |-> (clamp && !pos && !neg)); // R6
  AST_IDLE_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (clamp && !pos && !neg)); // R1
endmodule

// File: rtl/tx_pulse_seq.sv
`timescale 1ns/1ps
module tx_pulse_seq
  import txp_pkg::*;
#(
  parameter int N_CH   = 16,
  parameter int ADDR_W = $clog2(N_CH) + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              fire,
  output logic              busy,
  output logic              hv_sel,
  output logic [N_CH-1:0]   tx_pos,
  output logic [N_CH-1:0]   tx_neg,
  output logic [N_CH-1:0]   tx_clamp
);
  logic [N_CH-1:0][DLY_W-1:0] act_d;
  logic [N_CH-1:0][WID_W-1:0] act_w;
  logic [N_CH-1:0]            ch_done;
  logic                       all_done;
  logic                       load;
  logic [T_W-1:0]             t;

  assign all_done = &ch_done;

  txp_regs #(.N_CH(N_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cs(cs), .addr(addr), .wdata(wdata),
    .load(load), .act_d(act_d), .act_w(act_w), .act_hv(hv_sel)
  );

  txp_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .fire(fire), .all_done(all_done),
    .busy(busy), .load(load), .t(t)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_chan
    txp_chan u_chan (
      .clk(clk), .rst_n(rst_n), .busy(busy), .t(t),
      .d(act_d[i]), .w(act_w[i]),
      .pos(tx_pos[i]), .neg(tx_neg[i]), .clamp(tx_clamp[i]),
      .done(ch_done[i])
    );
  end

  AST_HV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(hv_sel)); // R10
  AST_DRIVE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (|(tx_pos | tx_neg)) |-> busy); // R1
endmodule

// File: tb/sim_tx_pulse_seq.sv
`timescale 1ns/1ps
module sim_tx_pulse_seq;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        fire = 1'b0;
  logic        busy, hv_sel;
  logic [N-1:0] tx_pos, tx_neg, tx_clamp;

  int total = 0;
  int bad = 0;

  // bench model: shadow and active configuration
  int sd[N], sw[N], ad[N], aw[N];
  int nd[N], nw[N];
  int shv = 0, ahv = 0, nhv = 0;

  always #2.5 clk = ~clk;

  tx_pulse_seq u0 (
    .clk(clk), .rst_n(rst_n), .cs(cs), .addr(addr), .wdata(wdata),
    .fire(fire), .busy(busy), .hv_sel(hv_sel),
    .tx_pos(tx_pos), .tx_neg(tx_neg), .tx_clamp(tx_clamp)
  );

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // expected output code: 0 clamp, 1 none (dead), 2 pos, 3 neg
  function automatic int expect_code(int k, int d, int w);
    int r;
    if (w == 0) return 0;
    r = k;
    if (r < d) return 0;
    r -= d;
    if (r < 1) return 1;
    r -= 1;
    if (r < w) return 2;
    r -= w;
    if (r < 1) return 1;
    r -= 1;
    if (r < w) return 3;
    r -= w;
    if (r < 1) return 1;
    return 0;
  endfunction

  function automatic int last_busy();
    int m = 0;
    for (int i = 0; i < N; i++)
      if (aw[i] != 0 && ad[i] + 2 * aw[i] + 2 > m) m = ad[i] + 2 * aw[i] + 2;
    return m;
  endfunction

  task automatic check(input string tag, input logic ok, input string what,
                       input int got, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s got=%0h exp=%0h", tag, what, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input int v);
    @(negedge clk);
    cs = 1'b1; addr = a; wdata = 16'(v);
    @(negedge clk);
    cs = 1'b0;
    if (a[5]) shv = v & 1;
    else if (a[4]) sw[a[3:0]] = v & 8'hff;
    else sd[a[3:0]] = v & 10'h3ff;
  endtask

  task automatic program_all(input int hv);
    for (int i = 0; i < N; i++) begin
      wr({2'b00, 4'(i)}, sd[i]);
      wr({2'b01, 4'(i)}, sw[i]);
    end
    wr(6'h20, hv);
  endtask

  // one firing; checks every cycle until one past busy end
  task automatic run_fire(input string tag, input int mid_fire_k, input bit mid_write);
    int tend, errs_o, errs_b, errs_h;
    logic [N-1:0] ep, en, ec;
    @(negedge clk);
    fire = 1'b1;
    for (int i = 0; i < N; i++) begin ad[i] = sd[i]; aw[i] = sw[i]; end
    ahv = shv;
    tend = last_busy();
    @(negedge clk);
    fire = 1'b0;
    errs_o = 0; errs_b = 0; errs_h = 0;
    for (int k = 0; k <= tend + 1; k++) begin
      for (int i = 0; i < N; i++) begin
        int c;
        c = (k <= tend) ? expect_code(k, ad[i], aw[i]) : 0;
        ec[i] = (c == 0); ep[i] = (c == 2); en[i] = (c == 3);
      end
      if (tx_pos !== ep || tx_neg !== en || tx_clamp !== ec) begin
        errs_o++;
        $display("FAIL %s outputs k=%0d got=%h/%h/%h exp=%h/%h/%h", tag, k,
                 tx_pos, tx_neg, tx_clamp, ep, en, ec);
      end
      if (busy !== (k <= tend)) begin
        errs_b++;
        $display("FAIL %s R9 busy k=%0d got=%0b exp=%0b", tag, k, busy, (k <= tend));
      end
      if (hv_sel !== ahv[0]) begin
        errs_h++;
        $display("FAIL %s R10 hv_sel k=%0d got=%0b exp=%0b", tag, k, hv_sel, ahv[0]);
      end
      fire = (k == mid_fire_k);
      cs = 1'b0;
      if (mid_write && k >= 2 && k < 2 + 2 * N + 1) begin
        int idx;
        idx = k - 2;
        cs = 1'b1;
        if (idx < N) begin
          addr = {2'b00, 4'(idx)}; wdata = 16'(nd[idx]); sd[idx] = nd[idx];
        end else if (idx < 2 * N) begin
          addr = {2'b01, 4'(idx - N)}; wdata = 16'(nw[idx - N]); sw[idx - N] = nw[idx - N];
        end else begin
          addr = 6'h20; wdata = 16'(nhv); shv = nhv;
        end
      end
      @(negedge clk);
    end
    fire = 1'b0; cs = 1'b0;
    total += 3;
    if (errs_o != 0) bad++;
    if (errs_b != 0) bad++;
    if (errs_h != 0) bad++;
  endtask

  task automatic t_reset();
    check("R1", tx_clamp === '1, "reset clamp", int'(tx_clamp), 16'hffff);
    check("R1", tx_pos === '0 && tx_neg === '0, "reset drive", int'(tx_pos | tx_neg), 0);
    check("R1", busy === 1'b0, "reset busy", int'(busy), 0);
    check("R1", hv_sel === 1'b0, "reset hv_sel", int'(hv_sel), 0);
  endtask

  task automatic t_stagger();
    for (int i = 0; i < N; i++) begin sd[i] = 3 * i; sw[i] = 1 + (i % 4); end
    program_all(0);
    run_fire("R2 R3 R4 R5 stagger", -1, 1'b0);
  endtask

  task automatic t_halfstep();
    for (int i = 0; i < N; i++) begin sd[i] = 20 + i; sw[i] = 3; end
    program_all(1);
    run_fire("R3 halfstep", -1, 1'b0);
  endtask

  task automatic t_zero();
    for (int i = 0; i < N; i++) begin sd[i] = i; sw[i] = (i % 3 == 0) ? 0 : 2; end
    program_all(0);
    run_fire("R6 zero width", -1, 1'b0);
  endtask

  task automatic t_allzero();
    for (int i = 0; i < N; i++) begin sd[i] = 7 * i; sw[i] = 0; end
    program_all(0);
    run_fire("R6 R9 all zero", -1, 1'b0);
  endtask

  task automatic t_shadow();
    for (int i = 0; i < N; i++) begin
      sd[i] = 40 + i; sw[i] = 4;
      nd[i] = 2 * i;  nw[i] = 1 + (i % 2);
    end
    nhv = 1;
    program_all(0);
    run_fire("R7 R10 writes during firing", -1, 1'b1);
    run_fire("R7 R10 new values applied", -1, 1'b0);
  endtask

  task automatic t_busy_fire();
    for (int i = 0; i < N; i++) begin sd[i] = 5 + 2 * i; sw[i] = 6; end
    program_all(1);
    run_fire("R8 fire while busy", 10, 1'b0);
    check("R8", busy === 1'b0, "idle after ignored fire", int'(busy), 0);
  endtask

  task automatic t_max();
    for (int i = 0; i < N; i++) begin sd[i] = 0; sw[i] = 0; end
    sd[0] = 1023; sw[0] = 255;
    sd[N-1] = 0;  sw[N-1] = 255;
    program_all(0);
    run_fire("R3 R9 max values", -1, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin sd[i] = 0; sw[i] = 0; ad[i] = 0; aw[i] = 0; end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stagger();
    t_halfstep();
    t_zero();
    t_allzero();
    t_shadow();
    t_busy_fire();
    t_max();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule